// File: doc/BRIEF.md
# Command-Driven Random Word Generator with Auto-Reseed

This block is a register-mapped random source. Software picks an output length and writes a command code. The block then either fills a bank of result words from an internal pseudo-random generator or reloads that generator from a seed input. When an operation finishes, a sticky status flag is raised. Software clears the flag by writing a 1 to it, and can route it to an interrupt line through per-source enables and a global enable.

The generator is a 32-bit xorshift whose seed is supplied on a port. This makes every output predictable in simulation. A programmable limit makes the block reseed itself once enough 16-byte blocks of output have been produced. A fixed identification word can be read back so that software can tell it is talking to the right block. The ready flag can come out of reset already set, so software has to be able to clear it before its first request.

Top module: `trng_regblk`

## Requirements
- R1: After reset, offset 0xF0 reads 0x000046BC, status (offset 0x14) reads 0x1 (ready set, seed-done clear), offsets 0x00/0x08/0x10/0x60 read 0, and `irq` is 0.
- R2: Writing a 1 to status bit 0 (ready) or bit 1 (seed-done) clears that bit; writing 0 to a bit leaves it unchanged.
- R3: Writing code 1 to offset 0x00 with mode bit 3 = 1 fills all eight result words (offsets 0x20, 0x24, … 0x3C) with successive generator outputs and then sets status bit 0. A generator step is s ^= s<<13; s ^= s>>17; s ^= s<<5, and word k holds the (k+1)-th step from the state before the command.
- R4: With mode bit 3 = 0, code 1 fills only words 0 to 3; words 4 to 7 keep their previous values.
- R5: Writing code 2 reloads the generator state with `seed_in | 1` after `SEED_CYCLES` cycles and sets status bit 1. Later outputs continue from that state.
- R6: With a nonzero limit L at offset 0x60, each completed random command adds 1 (128-bit) or 2 (256-bit) to a block count. The random command that brings the count to L or more is followed by an automatic reseed, which sets status bit 1 and restarts the count. L = 0 disables automatic reseeding. Writing the limit also restarts the count.
- R7: `irq` = IE bit 31 AND ((IE bit 0 AND status bit 0) OR (IE bit 1 AND status bit 1)), where IE is offset 0x10.
- R8: A command written while an operation (including an automatic reseed) is in progress has no effect.
- R9: Codes 0 and 3 start nothing: no flag is set and no result word changes.
- R10: Mode reads back bit 3 only, IE reads back bits 31, 1 and 0 only, the limit reads back its low `CNT_W` bits, and unmapped offsets read 0. Read data appears on `bus_rdata` one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| seed_in | input | 32 | Seed value loaded on a reseed |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with eight result words, a four-cycle reseed, an 8-bit limit counter and a known initial generator state. It computes every result word with its own xorshift model. The small limit width lets it sweep limits 1 to 3 with 128-bit commands and confirm that the automatic reseed lands on exactly the L-th command. Mixed 256/128-bit runs cover the two-block increment. Back-to-back writes reach the busy window, so the bench can show that a command arriving there is dropped.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GEN  = 2'd1,
    SEQ_SEED = 2'd2
  } seq_st_e;

  localparam logic [1:0] CODE_RAND = 2'd1;
  localparam logic [1:0] CODE_SEED = 2'd2;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h08;
  localparam logic [7:0] OFS_IE   = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_LIM  = 8'h60;
  localparam logic [7:0] OFS_VER  = 8'hF0;
  localparam logic [31:0] VER_CODE = 32'h0000_46BC;

  function automatic logic [WORD_W-1:0] xs_step(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/trng_prng.sv
module trng_prng
  import trng_pkg::*;
#(
  parameter logic [WORD_W-1:0] INIT_STATE = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [WORD_W-1:0] seed,
  output logic [WORD_W-1:0] rnd
);
  logic [WORD_W-1:0] s_q, s_d;

  assign rnd = xs_step(s_q);

  always_comb begin
    s_d = s_q;
    if (load)      s_d = seed | {{(WORD_W-1){1'b0}}, 1'b1};
    else if (step) s_d = rnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            s_q <= INIT_STATE;
    else if (load || step) s_q <= s_d;
  end
endmodule

// File: rtl/trng_seq.sv
module trng_seq
  import trng_pkg::*;
#(
  parameter int NWORDS      = 8,
  parameter int SEED_CYCLES = 4,
  parameter int CNT_W       = 16,
  localparam int IDX_W      = $clog2(NWORDS),
  localparam int CYC_W      = $clog2(NWORDS + SEED_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_code,
  input  logic             wide,
  input  logic [CNT_W-1:0] lim,
  input  logic             lim_wr,
  output logic             step,
  output logic [IDX_W-1:0] widx,
  output logic             load,
  output logic             rand_done,
  output logic             seed_done,
  output logic             busy,
  output logic [1:0]       op_code,
  output logic [CNT_W:0]   blk_cnt
);
  localparam int BLK_FULL = NWORDS / 4;
  localparam int BLK_HALF = NWORDS / 8;

  seq_st_e          st_q, st_d;
  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             wide_q, wide_d;
  logic [CNT_W:0]   blk_q, blk_d, blk_sum;
  logic [CYC_W-1:0] last_idx;

  assign last_idx = wide_q ? CYC_W'(NWORDS - 1) : CYC_W'(NWORDS / 2 - 1);
  assign blk_sum  = blk_q + (wide_q ? (CNT_W+1)'(BLK_FULL) : (CNT_W+1)'(BLK_HALF));
  assign widx     = cnt_q[IDX_W-1:0];
  assign busy     = (st_q != SEQ_IDLE);
  assign op_code  = (st_q == SEQ_GEN) ? CODE_RAND : (st_q == SEQ_SEED) ? CODE_SEED : 2'd0;
  assign blk_cnt  = blk_q;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    wide_d    = wide_q;
    blk_d     = blk_q;
    step      = 1'b0;
    load      = 1'b0;
    rand_done = 1'b0;
    seed_done = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (cmd_wr && cmd_code == CODE_RAND) begin
          st_d   = SEQ_GEN;
          cnt_d  = '0;
          wide_d = wide;
        end else if (cmd_wr && cmd_code == CODE_SEED) begin
          st_d  = SEQ_SEED;
          cnt_d = '0;
        end
      end
      SEQ_GEN: begin
        step = 1'b1;
        if (cnt_q == last_idx) begin
          rand_done = 1'b1;
          st_d      = SEQ_IDLE;
          if (lim != '0) begin
            if (blk_sum >= {1'b0, lim}) begin
              st_d  = SEQ_SEED;
              cnt_d = '0;
              blk_d = '0;
            end else begin
              blk_d = blk_sum;
            end
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_SEED: begin
        if (cnt_q == CYC_W'(SEED_CYCLES - 1)) begin
          load      = 1'b1;
          seed_done = 1'b1;
          st_d      = SEQ_IDLE;
          blk_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
    if (lim_wr) blk_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wide_q <= wide_d;
      blk_q  <= blk_d;
    end
  end
endmodule

// File: rtl/trng_regblk.sv
module trng_regblk
  import trng_pkg::*;
#(
  parameter int                NWORDS       = 8,
  parameter int                SEED_CYCLES  = 4,
  parameter int                CNT_W        = 16,
  parameter logic [WORD_W-1:0] INIT_STATE   = 32'h1234_5678,
  parameter bit                RDY_AT_RESET = 1'b1,
  localparam int               IDX_W        = $clog2(NWORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] seed_in,
  output logic        irq
);
  logic             wr_en, rd_en, cmd_wr, lim_wr;
  logic             mode_wide, ie_glb, ie_seed, ie_rdy, st_rdy, st_seed;
  logic             mode_wide_d, ie_glb_d, ie_seed_d, ie_rdy_d, st_rdy_d, st_seed_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [31:0]      rdata_q, rdata_d;
  logic [WORD_W-1:0] word_q [NWORDS];
  logic [WORD_W-1:0] rnd;
  logic             step, load, rand_done, seed_done, busy;
  logic [IDX_W-1:0] widx;
  logic [1:0]       op_code;
  logic [CNT_W:0]   blk_cnt;

  assign wr_en  = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign cmd_wr = wr_en && (bus_addr == OFS_CMD);
  assign lim_wr = wr_en && (bus_addr == OFS_LIM);

  trng_prng #(.INIT_STATE(INIT_STATE)) u_prng (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load), .seed(seed_in), .rnd(rnd)
  );

  trng_seq #(.NWORDS(NWORDS), .SEED_CYCLES(SEED_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(bus_wdata[1:0]),
    .wide(mode_wide), .lim(lim_q), .lim_wr(lim_wr), .step(step), .widx(widx),
    .load(load), .rand_done(rand_done), .seed_done(seed_done), .busy(busy),
    .op_code(op_code), .blk_cnt(blk_cnt)
  );

  always_comb begin
    mode_wide_d = mode_wide;
    ie_glb_d    = ie_glb;
    ie_seed_d   = ie_seed;
    ie_rdy_d    = ie_rdy;
    lim_d       = lim_q;
    st_rdy_d    = st_rdy;
    st_seed_d   = st_seed;
    if (wr_en && bus_addr == OFS_MODE) mode_wide_d = bus_wdata[3];
    if (wr_en && bus_addr == OFS_IE) begin
      ie_glb_d  = bus_wdata[31];
      ie_seed_d = bus_wdata[1];
      ie_rdy_d  = bus_wdata[0];
    end
    if (lim_wr) lim_d = bus_wdata[CNT_W-1:0];
    if (wr_en && bus_addr == OFS_STAT) begin
      if (bus_wdata[0]) st_rdy_d  = 1'b0;
      if (bus_wdata[1]) st_seed_d = 1'b0;
    end
    if (rand_done) st_rdy_d  = 1'b1;
    if (seed_done) st_seed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_wide <= 1'b0;
      ie_glb    <= 1'b0;
      ie_seed   <= 1'b0;
      ie_rdy    <= 1'b0;
      lim_q     <= '0;
      st_rdy    <= RDY_AT_RESET;
      st_seed   <= 1'b0;
    end else begin
      mode_wide <= mode_wide_d;
      ie_glb    <= ie_glb_d;
      ie_seed   <= ie_seed_d;
      ie_rdy    <= ie_rdy_d;
      lim_q     <= lim_d;
      st_rdy    <= st_rdy_d;
      st_seed   <= st_seed_d;
    end
  end

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic we;
    assign we = step && (widx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q[gi] <= '0;
      else if (we) word_q[gi] <= rnd;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (bus_addr[7:5] == 3'b001) begin
      rdata_d = word_q[bus_addr[IDX_W+1:2]];
    end else begin
      case (bus_addr)
        OFS_CMD:  rdata_d = {30'd0, op_code};
        OFS_MODE: rdata_d = {28'd0, mode_wide, 3'd0};
        OFS_IE:   rdata_d = {ie_glb, 29'd0, ie_seed, ie_rdy};
        OFS_STAT: rdata_d = {30'd0, st_seed, st_rdy};
        OFS_LIM:  rdata_d = {{(32-CNT_W){1'b0}}, lim_q};
        OFS_VER:  rdata_d = VER_CODE;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq = ie_glb && ((ie_rdy && st_rdy) || (ie_seed && st_seed));
endmodule

// File: rtl/trng_regblk_chk.sv
module trng_regblk_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ie_glb,
  input logic             rand_done,
  input logic             seed_done,
  input logic             st_rdy,
  input logic             st_seed,
  input logic             step,
  input logic [31:0]      word0,
  input logic             busy,
  input logic [CNT_W:0]   blk_cnt,
  input logic [CNT_W-1:0] lim_q
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_glb); // R7
  AST_RDY_AFTER_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    rand_done |=> st_rdy); // R3
  AST_SEED_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done |=> st_seed); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(word0)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && lim_q != '0) |-> (blk_cnt < {1'b0, lim_q})); // R6
  AST_NO_SEED_IN_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !seed_done); // R8
endmodule

bind trng_regblk trng_regblk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ie_glb(ie_glb), .rand_done(rand_done),
  .seed_done(seed_done), .st_rdy(st_rdy), .st_seed(st_seed), .step(step),
  .word0(word_q[0]), .busy(busy), .blk_cnt(blk_cnt), .lim_q(lim_q)
);

// File: tb/tb_trng_regblk.sv
module tb_trng_regblk;
  localparam logic [31:0] INIT = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, seed_in = 32'h0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] m;
  logic [31:0] expw [8];
  logic [31:0] rd;

  always #4 clk = ~clk;

  trng_regblk #(.NWORDS(8), .SEED_CYCLES(4), .CNT_W(8), .INIT_STATE(INIT),
                .RDY_AT_RESET(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seed_in(seed_in), .irq(irq)
  );

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_gen(input int nw);
    for (int k = 0; k < nw; k++) begin
      m = xs(m);
      expw[k] = m;
    end
  endtask

  task automatic chk_words(input string tag);
    for (int k = 0; k < 8; k++) begin
      rdreg(8'h20 + 8'(4 * k), rd);
      chk(tag, rd, expw[k]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m = INIT;
    for (int k = 0; k < 8; k++) expw[k] = 32'h0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rdreg(8'hF0, rd); chk("R1 version", rd, 32'h46BC);
    rdreg(8'h14, rd); chk("R1 status", rd, 32'h1);
    rdreg(8'h00, rd); chk("R1 cmd", rd, 32'h0);
    rdreg(8'h08, rd); chk("R1 mode", rd, 32'h0);
    rdreg(8'h10, rd); chk("R1 ie", rd, 32'h0);
    rdreg(8'h60, rd); chk("R1 limit", rd, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 clear pre-set ready flag
    wr(8'h14, 32'h1);
    rdreg(8'h14, rd); chk("R2 clear ready", rd, 32'h0);

    // R10 readback masks and unmapped
    wr(8'h08, 32'hFFFF_FFFF); rdreg(8'h08, rd); chk("R10 mode mask", rd, 32'h8);
    wr(8'h10, 32'hFFFF_FFFC); rdreg(8'h10, rd); chk("R10 ie mask", rd, 32'h8000_0000);
    wr(8'h10, 32'h0);
    rdreg(8'h04, rd); chk("R10 unmapped", rd, 32'h0);
    wr(8'h60, 32'h0000_1234); rdreg(8'h60, rd); chk("R10 limit width", rd, 32'h34);
    wr(8'h60, 32'h0);

    // R3 256-bit generation
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    model_gen(8);
    idle(20);
    rdreg(8'h14, rd); chk("R3 ready set", rd, 32'h1);
    chk_words("R3 words");

    // R2 write 0 keeps, write 1 clears
    wr(8'h14, 32'h0); rdreg(8'h14, rd); chk("R2 write0 keeps", rd, 32'h1);
    wr(8'h14, 32'h1); rdreg(8'h14, rd); chk("R2 write1 clears", rd, 32'h0);

    // R4 128-bit generation
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    model_gen(4);
    idle(20);
    chk_words("R4 half words");
    rdreg(8'h14, rd); chk("R4 ready", rd, 32'h1);
    wr(8'h14, 32'h1);

    // R5 commanded reseed
    seed_in = 32'hCAFE_BABE;
    wr(8'h00, 32'h2);
    idle(2);
    rdreg(8'h14, rd); chk("R5 seed not early", rd, 32'h0);
    idle(10);
    rdreg(8'h14, rd); chk("R5 seed done", rd, 32'h2);
    m = 32'hCAFE_BABF;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    model_gen(8);
    idle(20);
    chk_words("R5 reseeded words");

    // R7 interrupt combinations (status = seed|ready)
    wr(8'h10, 32'h3); chk("R7 no global", {31'd0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0001); chk("R7 ready path", {31'd0, irq}, 32'h1);
    wr(8'h14, 32'h1); chk("R7 ready cleared", {31'd0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0002); chk("R7 seed path", {31'd0, irq}, 32'h1);
    wr(8'h14, 32'h2); chk("R7 seed cleared", {31'd0, irq}, 32'h0);
    wr(8'h10, 32'h0);

    // R8 command while busy dropped
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h2);
    model_gen(8);
    idle(20);
    rdreg(8'h14, rd); chk("R8 no seed", rd, 32'h1);
    chk_words("R8 words");
    wr(8'h14, 32'h3);

    // R9 codes 0 and 3
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h3);
    idle(20);
    rdreg(8'h14, rd); chk("R9 no flags", rd, 32'h0);
    chk_words("R9 words kept");

    // R6 mixed-width auto reseed, limit 3
    seed_in = 32'h0BAD_F00D;
    wr(8'h60, 32'h3);
    wr(8'h00, 32'h1);
    model_gen(8);
    idle(20);
    rdreg(8'h14, rd); chk("R6 two blocks no reseed", rd, 32'h1);
    wr(8'h14, 32'h3);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    model_gen(4);
    idle(25);
    rdreg(8'h14, rd); chk("R6 third block reseeds", rd, 32'h3);
    wr(8'h14, 32'h3);
    m = 32'h0BAD_F00D;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    model_gen(8);
    idle(20);
    chk_words("R6 words after auto seed");
    wr(8'h14, 32'h3);

    // R6 sweep limits 1..3 with 128-bit commands
    wr(8'h08, 32'h0);
    for (int lim = 1; lim <= 3; lim++) begin
      seed_in = 32'h1000_0000 + 32'(lim);
      wr(8'h60, 32'(lim));
      for (int k = 1; k <= lim; k++) begin
        wr(8'h00, 32'h1);
        idle(25);
        rdreg(8'h14, rd);
        chk("R6 sweep seed flag", rd, (k == lim) ? 32'h3 : 32'h1);
        wr(8'h14, 32'h3);
      end
    end

    // R6 limit 0 disables
    wr(8'h60, 32'h0);
    for (int k = 0; k < 4; k++) begin
      wr(8'h00, 32'h1);
      idle(20);
    end
    rdreg(8'h14, rd); chk("R6 disabled", rd, 32'h1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule